// File: doc/BRIEF.md
# Decoded Micro-op Cache

This block keeps micro-ops that have already been decoded, so the front end does not have to decode the same code twice. Entries are keyed by the instruction-pointer address of an aligned 32-byte code window. A window may fill several ways of its set. Each way carries up to six opaque micro-op tokens, and a window may span at most three ways (18 micro-ops).

A fetch address is presented on the lookup port. One cycle after the lookup is accepted, one of two things happens:
- **Hit:** the window's micro-ops stream toward the micro-op queue, one way per beat, in segment order, under valid/ready handshaking. A clock-gate enable for the legacy decoder is held high for as long as the stream lasts.
- **Miss:** a one-cycle pulse, carrying the fetch address, selects the legacy decode path.

The legacy decoder's output for a whole window comes back on the fill port. A window that needs more micro-ops than the limit is dropped and therefore always misses.

Replacement is tree pseudo-LRU per set. When a fill finds too few free ways, it evicts whole victim windows, all of their ways at once, so no partial window is ever left behind. A flush input clears every entry in one cycle. Hit and miss counters are exported for trace-level hit-rate checks.

Top module: `uop_cache`

## Requirements
- R1: The set index is address bits [9:5] and the tag is bits [31:10]. Bits [4:0] are ignored, so any byte address inside a cached window hits it. A different tag or a different set misses.
- R2: After a fill of N micro-ops (1 ≤ N ≤ 18), a lookup hits and delivers ceil(N/6) beats. Beat k carries uq_cnt = min(6, N−6k). Slot j of beat k, at bits [16j+15:16j], holds fill token 6k+j, where fill token i is fill_uops[16i+15:16i]. uq_last is set only on the final beat.
- R3: A fill with N = 0 or N > 18 installs nothing, and later lookups of that window miss.
- R4: On a hit, uq_valid and dec_gate_en rise one cycle after the lookup is accepted and stay high until the final beat is taken. At all other times dec_gate_en is low.
- R5: On a miss, miss_valid is high for exactly one cycle, one cycle after acceptance, with miss_addr equal to the lookup address. No stream starts and dec_gate_en stays low.
- R6: While uq_ready is low, uq_valid, uq_uops and uq_cnt hold steady.
- R7: With all 8 ways of a set in use, a 3-way fill evicts whole windows chosen by tree pseudo-LRU until 3 ways are free. After eight one-way windows are filled into ways 0..7 and way 0 is then hit, the windows in ways 4, 5 and 6 are evicted and the others remain.
- R8: After a one-cycle flush pulse, every lookup misses until it is refilled.
- R9: hit_cnt and miss_cnt reset to 0, and each rises by one for every accepted lookup that hits or misses respectively.
- R10: Refilling a window that is already cached replaces it, and a later hit returns only the new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries; aborts any stream or fill in progress |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup accepted this cycle (idle, no flush, no fill offered) |
| lk_addr | input | 32 | Fetch address |
| miss_valid | output | 1 | One-cycle miss pulse selecting legacy decode |
| miss_addr | output | 32 | Address of the missed lookup |
| uq_valid | output | 1 | Beat valid toward the micro-op queue |
| uq_ready | input | 1 | Queue accepts the beat |
| uq_uops | output | 96 | Six 16-bit micro-op slots, slot 0 in the low bits |
| uq_cnt | output | 3 | Valid slots in this beat |
| uq_last | output | 1 | Final beat of the window |
| dec_gate_en | output | 1 | Legacy decoder clock-gate enable |
| fill_valid | input | 1 | Decoded window offered for install (has priority over lookup) |
| fill_ready | output | 1 | Fill accepted this cycle |
| fill_addr | input | 32 | Any address inside the decoded window |
| fill_cnt | input | 6 | Number of micro-ops the window decoded to |
| fill_uops | input | 288 | Up to 18 tokens, token 0 in the low bits |
| hit_cnt | output | 16 | Accepted lookups that hit |
| miss_cnt | output | 16 | Accepted lookups that missed |

## Verification
On every cycle, the embedded properties check several things:
- the queue interface holds its beat under back-pressure, and every beat carries 1 to 6 tokens;
- the gate enable rises only after a hit, and a miss pulse never overlaps a stream;
- flush empties the array, and no oversized or empty window is ever written;
- the allocator writes exactly as many free ways as needed, and the pseudo-LRU victim is always a valid way.

Only the directed scenarios can show the rest: the token order and counts across beats, the address split into tag, set and offset, exactly which windows the pseudo-LRU evicts, replacement on refill, and the counter totals across a trace.

// File: rtl/uc_pkg.sv
package uc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STREAM = 2'd1,
    ST_FILL   = 2'd2
  } uc_state_e;

  // Number of ways a window of 'total' tokens occupies.
  function automatic int ceil_div(input int total, input int per);
    return (total + per - 1) / per;
  endfunction

  // Tokens carried by segment 'seg' of a window of 'total' tokens.
  function automatic int seg_uops(input int total, input int seg, input int per);
    int rem;
    rem = total - seg * per;
    if (rem > per) rem = per;
    if (rem < 0) rem = 0;
    return rem;
  endfunction

endpackage

// File: rtl/uc_plru.sv
module uc_plru #(
  parameter int SETS = 32,
  parameter int WAYS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     touch_en,
  input  logic [$clog2(SETS)-1:0]  touch_set,
  input  logic [$clog2(WAYS)-1:0]  touch_way,
  input  logic [$clog2(SETS)-1:0]  q_set,
  input  logic [WAYS-1:0]          q_mask,
  output logic [$clog2(WAYS)-1:0]  victim
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-2:0] tree_q [SETS];

  // Walk toward the LRU side, detouring when that side holds no eligible way.
  function automatic logic [WAY_W-1:0] pick(input logic [WAYS-2:0] t, input logic [WAYS-1:0] m);
    int node, lo, half;
    logic l_any, r_any;
    node = 0; lo = 0;
    for (int l = 0; l < WAY_W; l++) begin
      half  = WAYS >> (l + 1);
      l_any = 1'b0; r_any = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
        if (w >= lo && w < lo + half && m[w]) l_any = 1'b1;
        if (w >= lo + half && w < lo + 2 * half && m[w]) r_any = 1'b1;
      end
      if ((!t[node] && l_any) || !r_any) node = 2 * node + 1;
      else begin lo = lo + half; node = 2 * node + 2; end
    end
    return lo[WAY_W-1:0];
  endfunction

  function automatic logic [WAYS-2:0] touch(input logic [WAYS-2:0] t, input logic [WAY_W-1:0] way);
    logic [WAYS-2:0] r;
    int node, lo, half;
    r = t; node = 0; lo = 0;
    for (int l = 0; l < WAY_W; l++) begin
      half = WAYS >> (l + 1);
      if (int'(way) < lo + half) begin r[node] = 1'b1; node = 2 * node + 1; end
      else begin r[node] = 1'b0; lo = lo + half; node = 2 * node + 2; end
    end
    return r;
  endfunction

  assign victim = pick(tree_q[q_set], q_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[touch_set] <= touch(tree_q[touch_set], touch_way);
    end
  end

  AST_VICTIM_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (q_mask != '0) |-> q_mask[victim]);  // R7

endmodule

// File: rtl/uc_match.sv
module uc_match #(
  parameter int WAYS     = 8,
  parameter int TAG_W    = 22,
  parameter int SEG_W    = 2,
  parameter int MAX_SEGS = 3
) (
  input  logic [WAYS-1:0]                          way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]               way_tag,
  input  logic [WAYS-1:0][SEG_W-1:0]               way_seg,
  input  logic [WAYS-1:0]                          way_last,
  input  logic [TAG_W-1:0]                         look_tag,
  output logic [WAYS-1:0]                          match,
  output logic                                     complete,
  output logic [SEG_W-1:0]                         last_seg,
  output logic [MAX_SEGS-1:0][$clog2(WAYS)-1:0]    way_of_seg
);
  localparam int WAY_W = $clog2(WAYS);

  logic [MAX_SEGS-1:0] have;
  logic                have_last;

  always_comb begin
    have       = '0;
    have_last  = 1'b0;
    last_seg   = '0;
    way_of_seg = '0;
    for (int w = 0; w < WAYS; w++) match[w] = way_valid[w] && (way_tag[w] == look_tag);
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) begin
        for (int s = 0; s < MAX_SEGS; s++) begin
          if (way_seg[w] == SEG_W'(s)) begin
            have[s]       = 1'b1;
            way_of_seg[s] = WAY_W'(w);
          end
        end
        if (way_last[w]) begin
          have_last = 1'b1;
          last_seg  = way_seg[w];
        end
      end
    end
    // A hit needs the closing segment and every segment before it.
    complete = have_last;
    for (int s = 0; s < MAX_SEGS; s++)
      if (SEG_W'(s) <= last_seg && !have[s]) complete = 1'b0;
  end

endmodule

// File: rtl/uc_alloc.sv
module uc_alloc #(
  parameter int WAYS     = 8,
  parameter int SEG_W    = 2,
  parameter int MAX_SEGS = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [WAYS-1:0]                   way_valid,
  input  logic [$clog2(MAX_SEGS+1)-1:0]     need,
  output logic [WAYS-1:0]                   wr_mask,
  output logic [WAYS-1:0][SEG_W-1:0]        wr_seg,
  output logic                              fits
);
  int k;
  int n_free;

  // Lowest-numbered free ways take segments 0, 1, ... in order.
  always_comb begin
    k       = 0;
    n_free  = 0;
    wr_mask = '0;
    wr_seg  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!way_valid[w]) begin
        n_free = n_free + 1;
        if (k < int'(need)) begin
          wr_mask[w] = 1'b1;
          wr_seg[w]  = SEG_W'(k);
          k          = k + 1;
        end
      end
    end
    fits = (n_free >= int'(need));
  end

  AST_ALLOC_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    fits |-> ($countones(wr_mask) == int'(need)));  // R7
  AST_ALLOC_FREE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask & way_valid) == '0);  // R7

endmodule

// File: rtl/uop_cache.sv
module uop_cache
  import uc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int UOP_W     = 16,
  parameter int SETS      = 32,
  parameter int WAYS      = 8,
  parameter int SLOTS     = 6,
  parameter int WIN_BYTES = 32,
  parameter int MAX_UOPS  = 18,
  parameter int CNT_W     = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush,
  input  logic                              lk_valid,
  output logic                              lk_ready,
  input  logic [ADDR_W-1:0]                 lk_addr,
  output logic                              miss_valid,
  output logic [ADDR_W-1:0]                 miss_addr,
  output logic                              uq_valid,
  input  logic                              uq_ready,
  output logic [SLOTS*UOP_W-1:0]            uq_uops,
  output logic [$clog2(SLOTS+1)-1:0]        uq_cnt,
  output logic                              uq_last,
  output logic                              dec_gate_en,
  input  logic                              fill_valid,
  output logic                              fill_ready,
  input  logic [ADDR_W-1:0]                 fill_addr,
  input  logic [$clog2(MAX_UOPS+1):0]       fill_cnt,
  input  logic [MAX_UOPS*UOP_W-1:0]         fill_uops,
  output logic [CNT_W-1:0]                  hit_cnt,
  output logic [CNT_W-1:0]                  miss_cnt
);
  localparam int OFF_W    = $clog2(WIN_BYTES);
  localparam int SET_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - OFF_W - SET_W;
  localparam int WAY_W    = $clog2(WAYS);
  localparam int MAX_SEGS = (MAX_UOPS + SLOTS - 1) / SLOTS;
  localparam int SEG_W    = (MAX_SEGS > 1) ? $clog2(MAX_SEGS) : 1;
  localparam int NEED_W   = $clog2(MAX_SEGS + 1);
  localparam int SCNT_W   = $clog2(SLOTS + 1);
  localparam int FCNT_W   = $clog2(MAX_UOPS + 1) + 1;
  localparam int SEG_BITS = SLOTS * UOP_W;
  localparam int FBUF_W   = MAX_SEGS * SEG_BITS;

  // ---------------- storage ----------------
  logic [SETS-1:0][WAYS-1:0] v_q;
  logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
  logic [SEG_W-1:0]          seg_q  [SETS][WAYS];
  logic [SCNT_W-1:0]         ucnt_q [SETS][WAYS];
  logic                      last_q [SETS][WAYS];
  logic [SEG_BITS-1:0]       data_q [SETS][WAYS];

  // ---------------- control state ----------------
  uc_state_e                          state_q;
  logic [TAG_W+SET_W-1:0]             f_win_q;
  logic [FCNT_W-1:0]                  f_cnt_q;
  logic [FBUF_W-1:0]                  f_uops_q;
  logic [SET_W-1:0]                   s_set_q;
  logic [MAX_SEGS-1:0][WAY_W-1:0]     s_way_q;
  logic [SEG_W-1:0]                   s_seg_q, s_last_q;
  logic                               miss_q;
  logic [ADDR_W-1:0]                  miss_addr_q;
  logic [CNT_W-1:0]                   hit_q, miss_cnt_q;

  // ---------------- set view ----------------
  logic [TAG_W+SET_W-1:0]             cur_win;
  logic [SET_W-1:0]                   cur_set;
  logic [TAG_W-1:0]                   cur_tag;
  logic [WAYS-1:0]                    set_valid;
  logic [WAYS-1:0][TAG_W-1:0]         set_tag;
  logic [WAYS-1:0][SEG_W-1:0]         set_seg;
  logic [WAYS-1:0]                    set_last;

  assign cur_win   = (state_q == ST_FILL) ? f_win_q : lk_addr[ADDR_W-1:OFF_W];
  assign cur_set   = cur_win[SET_W-1:0];
  assign cur_tag   = cur_win[TAG_W+SET_W-1:SET_W];
  assign set_valid = v_q[cur_set];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_tag[w]  = tag_q[cur_set][w];
      set_seg[w]  = seg_q[cur_set][w];
      set_last[w] = last_q[cur_set][w];
    end
  end

  logic [WAYS-1:0]                 m_match;
  logic                            m_complete;
  logic [SEG_W-1:0]                m_last_seg;
  logic [MAX_SEGS-1:0][WAY_W-1:0]  m_way_of_seg;

  uc_match #(.WAYS(WAYS), .TAG_W(TAG_W), .SEG_W(SEG_W), .MAX_SEGS(MAX_SEGS)) u_match (
    .way_valid(set_valid), .way_tag(set_tag), .way_seg(set_seg), .way_last(set_last),
    .look_tag(cur_tag), .match(m_match), .complete(m_complete),
    .last_seg(m_last_seg), .way_of_seg(m_way_of_seg)
  );

  // ---------------- fill planning ----------------
  logic [NEED_W-1:0]              need;
  logic [WAYS-1:0]                wr_mask;
  logic [WAYS-1:0][SEG_W-1:0]     wr_seg;
  logic                           alloc_fits;

  assign need = NEED_W'(ceil_div(int'(f_cnt_q), SLOTS));

  uc_alloc #(.WAYS(WAYS), .SEG_W(SEG_W), .MAX_SEGS(MAX_SEGS)) u_alloc (
    .clk(clk), .rst_n(rst_n), .way_valid(set_valid), .need(need),
    .wr_mask(wr_mask), .wr_seg(wr_seg), .fits(alloc_fits)
  );

  logic [WAY_W-1:0] victim;
  logic [WAYS-1:0]  ev_mask;
  logic             touch_en;
  logic [WAY_W-1:0] touch_way;
  logic [WAY_W-1:0] first_wr;

  always_comb begin
    ev_mask = '0;
    for (int w = 0; w < WAYS; w++)
      ev_mask[w] = set_valid[w] && (set_tag[w] == set_tag[victim]);
    first_wr = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (wr_mask[w]) first_wr = WAY_W'(w);
  end

  // ---------------- named events ----------------
  logic look_go, hit_evt, miss_evt, fill_go, fill_keep;
  logic in_fill, fill_dup, wr_en, evict_en;

  assign lk_ready   = (state_q == ST_IDLE) && !flush && !fill_valid;
  assign fill_ready = (state_q == ST_IDLE) && !flush;
  assign look_go    = lk_valid && lk_ready;
  assign hit_evt    = look_go && m_complete;
  assign miss_evt   = look_go && !m_complete;
  assign fill_go    = fill_valid && fill_ready;
  assign fill_keep  = (fill_cnt != '0) && (int'(fill_cnt) <= MAX_UOPS);
  assign in_fill    = (state_q == ST_FILL) && !flush;
  assign fill_dup   = in_fill && (m_match != '0);
  assign wr_en      = in_fill && !fill_dup && alloc_fits;
  assign evict_en   = in_fill && !fill_dup && !alloc_fits;
  assign touch_en   = hit_evt || wr_en;
  assign touch_way  = hit_evt ? m_way_of_seg[0] : first_wr;

  uc_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_set(cur_set),
    .touch_way(touch_way), .q_set(cur_set), .q_mask(set_valid), .victim(victim)
  );

  logic unused_addr_bits;
  assign unused_addr_bits = ^fill_addr[OFF_W-1:0];

  // ---------------- sequencing ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      miss_q   <= 1'b0;
      s_seg_q  <= '0;
      s_last_q <= '0;
    end else if (flush) begin
      state_q <= ST_IDLE;
      miss_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          miss_q <= 1'b0;
          if (fill_go) begin
            if (fill_keep) begin
              state_q  <= ST_FILL;
              f_win_q  <= fill_addr[ADDR_W-1:OFF_W];
              f_cnt_q  <= fill_cnt;
              f_uops_q <= FBUF_W'(fill_uops);
            end
          end else if (hit_evt) begin
            state_q  <= ST_STREAM;
            s_set_q  <= cur_set;
            s_way_q  <= m_way_of_seg;
            s_seg_q  <= '0;
            s_last_q <= m_last_seg;
          end else if (miss_evt) begin
            miss_q      <= 1'b1;
            miss_addr_q <= lk_addr;
          end
        end
        ST_STREAM: begin
          if (uq_ready) begin
            if (s_seg_q == s_last_q) state_q <= ST_IDLE;
            else s_seg_q <= s_seg_q + 1'b1;
          end
        end
        ST_FILL: begin
          if (wr_en) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q      <= '0;
      miss_cnt_q <= '0;
    end else begin
      if (hit_evt)  hit_q      <= hit_q + 1'b1;
      if (miss_evt) miss_cnt_q <= miss_cnt_q + 1'b1;
    end
  end

  // Valid bits: flush, partial-window purge, duplicate purge, eviction, install.
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      v_q <= '0;
    end else if (miss_evt) begin
      v_q[cur_set] <= set_valid & ~m_match;
    end else if (fill_dup) begin
      v_q[cur_set] <= set_valid & ~m_match;
    end else if (evict_en) begin
      v_q[cur_set] <= set_valid & ~ev_mask;
    end else if (wr_en) begin
      v_q[cur_set] <= set_valid | wr_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (wr_mask[w]) begin
          tag_q[cur_set][w]  <= cur_tag;
          seg_q[cur_set][w]  <= wr_seg[w];
          ucnt_q[cur_set][w] <= SCNT_W'(seg_uops(int'(f_cnt_q), int'(wr_seg[w]), SLOTS));
          last_q[cur_set][w] <= (int'(wr_seg[w]) == int'(need) - 1);
          data_q[cur_set][w] <= f_uops_q[int'(wr_seg[w]) * SEG_BITS +: SEG_BITS];
        end
      end
    end
  end

  // ---------------- outputs ----------------
  logic [WAY_W-1:0] s_way;
  assign s_way       = s_way_q[s_seg_q];
  assign uq_valid    = (state_q == ST_STREAM);
  assign uq_uops     = data_q[s_set_q][s_way];
  assign uq_cnt      = ucnt_q[s_set_q][s_way];
  assign uq_last     = (s_seg_q == s_last_q);
  assign dec_gate_en = (state_q == ST_STREAM);
  assign miss_valid  = miss_q;
  assign miss_addr   = miss_addr_q;
  assign hit_cnt     = hit_q;
  assign miss_cnt    = miss_cnt_q;

  // ---------------- assertions ----------------
  AST_UQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (uq_valid && !uq_ready && !flush) |=> (uq_valid && $stable(uq_uops) && $stable(uq_cnt)));  // R6
  AST_UQ_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    uq_valid |-> (uq_cnt != '0 && int'(uq_cnt) <= SLOTS));  // R2
  AST_NO_OVERSIZE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (f_cnt_q != '0 && int'(f_cnt_q) <= MAX_UOPS));  // R3
  AST_GATE_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_gate_en) |-> $past(hit_evt));  // R4
  AST_MISS_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> (!uq_valid && !dec_gate_en));  // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (v_q == '0));  // R8
  AST_HIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (hit_cnt == $past(hit_cnt) + 1'b1));  // R9

endmodule

// File: tb/uop_cache_tb.sv
`timescale 1ns/1ps
module uop_cache_tb;
  localparam int UW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic lk_valid = 1'b0;
  logic lk_ready;
  logic [31:0] lk_addr = '0;
  logic miss_valid;
  logic [31:0] miss_addr;
  logic uq_valid;
  logic uq_ready = 1'b1;
  logic [95:0] uq_uops;
  logic [2:0] uq_cnt;
  logic uq_last;
  logic dec_gate_en;
  logic fill_valid = 1'b0;
  logic fill_ready;
  logic [31:0] fill_addr = '0;
  logic [5:0] fill_cnt = '0;
  logic [287:0] fill_uops = '0;
  logic [15:0] hit_cnt, miss_cnt;

  int n_chk = 0;
  int n_bad = 0;
  int exp_hits = 0;
  int exp_miss = 0;

  always #4 clk = ~clk;

  uop_cache u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .miss_valid(miss_valid), .miss_addr(miss_addr),
    .uq_valid(uq_valid), .uq_ready(uq_ready), .uq_uops(uq_uops), .uq_cnt(uq_cnt),
    .uq_last(uq_last), .dec_gate_en(dec_gate_en),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
    .fill_cnt(fill_cnt), .fill_uops(fill_uops),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
  );

  function automatic logic [31:0] mk(input int tag, input int set, input int off);
    return 32'((tag << 10) | (set << 5) | off);
  endfunction

  function automatic logic [UW-1:0] tok(input logic [7:0] id, input int i);
    return {id, 8'(i)};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic do_fill(input logic [31:0] a, input int n, input logic [7:0] id);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a; fill_cnt = 6'(n); fill_uops = '0;
    for (int i = 0; i < 18 && i < n; i++) fill_uops[i*UW +: UW] = tok(id, i);
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // Presents one lookup; checks hit stream or miss pulse.
  task automatic lookup(input logic [31:0] a, input bit exp_hit, input int n,
                        input logic [7:0] id, input string rq);
    int beats;
    logic [95:0] ev, mask;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    chk(lk_ready == 1'b1, {rq, " lk_ready"}, 128'(lk_ready), 128'(1));
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    if (exp_hit) begin
      exp_hits++;
      beats = (n + 5) / 6;
      chk(miss_valid == 1'b0, {rq, " R5 no miss on hit"}, 128'(miss_valid), 128'(0));
      for (int k = 0; k < beats; k++) begin
        int c;
        c = (n - 6 * k > 6) ? 6 : n - 6 * k;
        ev = '0; mask = '0;
        for (int j = 0; j < c; j++) begin
          ev[j*UW +: UW] = tok(id, 6 * k + j);
          mask[j*UW +: UW] = '1;
        end
        chk(uq_valid && dec_gate_en, {rq, " R4 beat valid and gate"}, 128'({uq_valid, dec_gate_en}), 128'(3));
        chk(int'(uq_cnt) == c && uq_last == (k == beats - 1), {rq, " R2 cnt/last"},
            128'({uq_cnt, uq_last}), 128'({3'(c), (k == beats - 1)}));
        chk((uq_uops & mask) == ev, {rq, " R2 tokens"}, 128'(uq_uops & mask), 128'(ev));
        @(negedge clk);
      end
      chk(!uq_valid && !dec_gate_en, {rq, " R4 gate drops after last"}, 128'({uq_valid, dec_gate_en}), 128'(0));
    end else begin
      exp_miss++;
      chk(miss_valid && miss_addr == a, {rq, " R5 miss pulse/addr"}, 128'({miss_valid, miss_addr}), 128'({1'b1, a}));
      chk(!uq_valid && !dec_gate_en, {rq, " R5 no stream on miss"}, 128'({uq_valid, dec_gate_en}), 128'(0));
      @(negedge clk);
      chk(miss_valid == 1'b0, {rq, " R5 single-cycle pulse"}, 128'(miss_valid), 128'(0));
    end
  endtask

  task automatic t_reset;
    chk(lk_ready && fill_ready && !uq_valid && !miss_valid && !dec_gate_en, "R4 reset outputs",
        128'({lk_ready, fill_ready, uq_valid, miss_valid, dec_gate_en}), 128'(5'b11000));
    chk(hit_cnt == 0 && miss_cnt == 0, "R9 reset counters", 128'({hit_cnt, miss_cnt}), 128'(0));
  endtask

  task automatic t_address_split;
    lookup(mk(5, 2, 0), 1'b0, 0, 8'h0, "R5 cold miss");
    do_fill(mk(5, 2, 9), 4, 8'h01);
    lookup(mk(5, 2, 17), 1'b1, 4, 8'h01, "R1 offset ignored");
    lookup(mk(6, 2, 0), 1'b0, 0, 8'h0, "R1 other tag");
    lookup(mk(5, 3, 0), 1'b0, 0, 8'h0, "R1 other set");
  endtask

  task automatic t_multi_way;
    do_fill(mk(11, 4, 0), 13, 8'h02);
    lookup(mk(11, 4, 3), 1'b1, 13, 8'h02, "R2 thirteen tokens");
    do_fill(mk(12, 4, 0), 18, 8'h03);
    lookup(mk(12, 4, 0), 1'b1, 18, 8'h03, "R2 eighteen tokens");
    do_fill(mk(13, 4, 0), 12, 8'h04);
    lookup(mk(13, 4, 31), 1'b1, 12, 8'h04, "R2 twelve tokens");
    do_fill(mk(14, 4, 0), 6, 8'h05);
    lookup(mk(14, 4, 0), 1'b1, 6, 8'h05, "R2 six tokens");
  endtask

  task automatic t_oversize;
    do_fill(mk(20, 6, 0), 19, 8'h06);
    lookup(mk(20, 6, 0), 1'b0, 0, 8'h0, "R3 nineteen not installed");
    do_fill(mk(21, 6, 0), 0, 8'h07);
    lookup(mk(21, 6, 0), 1'b0, 0, 8'h0, "R3 zero not installed");
    do_fill(mk(22, 6, 0), 40, 8'h08);
    lookup(mk(22, 6, 0), 1'b0, 0, 8'h0, "R3 forty not installed");
  endtask

  task automatic t_stall;
    logic [95:0] first;
    do_fill(mk(7, 3, 0), 8, 8'h09);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = mk(7, 3, 0); uq_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    exp_hits++;
    first = uq_uops;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(uq_valid && dec_gate_en && uq_uops == first && uq_cnt == 3'd6, "R6 held while stalled",
          128'({uq_valid, dec_gate_en, uq_cnt}), 128'({2'b11, 3'd6}));
    end
    uq_ready = 1'b1;
    @(negedge clk);
    chk(uq_valid && uq_cnt == 3'd2 && uq_last, "R6 second beat after release",
        128'({uq_valid, uq_cnt, uq_last}), 128'({1'b1, 3'd2, 1'b1}));
    chk(uq_uops[31:0] == {tok(8'h09, 7), tok(8'h09, 6)}, "R6 second beat tokens",
        128'(uq_uops[31:0]), 128'({tok(8'h09, 7), tok(8'h09, 6)}));
    @(negedge clk);
    chk(!uq_valid && !dec_gate_en, "R4 stream ends", 128'({uq_valid, dec_gate_en}), 128'(0));
  endtask

  task automatic t_refill;
    do_fill(mk(5, 2, 0), 7, 8'h55);
    lookup(mk(5, 2, 0), 1'b1, 7, 8'h55, "R10 refill replaces");
  endtask

  task automatic t_plru;
    for (int t = 1; t <= 8; t++) do_fill(mk(t, 9, 0), 1, 8'(8'h10 + t));
    lookup(mk(1, 9, 0), 1'b1, 1, 8'h11, "R7 touch way 0");
    do_fill(mk(30, 9, 0), 15, 8'h30);
    lookup(mk(5, 9, 0), 1'b0, 0, 8'h0, "R7 way4 evicted");
    lookup(mk(6, 9, 0), 1'b0, 0, 8'h0, "R7 way5 evicted");
    lookup(mk(7, 9, 0), 1'b0, 0, 8'h0, "R7 way6 evicted");
    for (int t = 1; t <= 4; t++) lookup(mk(t, 9, 0), 1'b1, 1, 8'(8'h10 + t), "R7 survivor");
    lookup(mk(8, 9, 0), 1'b1, 1, 8'h18, "R7 way7 survives");
    lookup(mk(30, 9, 0), 1'b1, 15, 8'h30, "R7 three-way window");
  endtask

  task automatic t_flush;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    lookup(mk(5, 2, 0), 1'b0, 0, 8'h0, "R8 after flush A");
    lookup(mk(12, 4, 0), 1'b0, 0, 8'h0, "R8 after flush B");
    lookup(mk(30, 9, 0), 1'b0, 0, 8'h0, "R8 after flush C");
    do_fill(mk(12, 4, 0), 5, 8'h40);
    lookup(mk(12, 4, 0), 1'b1, 5, 8'h40, "R8 refill after flush");
  endtask

  task automatic t_counters;
    @(negedge clk);
    chk(int'(hit_cnt) == exp_hits, "R9 hit count", 128'(hit_cnt), 128'(exp_hits));
    chk(int'(miss_cnt) == exp_miss, "R9 miss count", 128'(miss_cnt), 128'(exp_miss));
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_address_split();
    t_multi_way();
    t_oversize();
    t_stall();
    t_refill();
    t_plru();
    t_flush();
    t_counters();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule